// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a set of general-purpose input pins and turns selected activity on them into interrupt requests. Each pin is given its own trigger condition: a rising edge, a falling edge, any edge, a high level or a low level. The condition is built from three independent configuration bit planes (sensitivity kind, polarity and any-edge). Every pin that meets its condition while enabled records a bit in a raw status word. A mask word removes pins from the masked status view and from the interrupt. A single interrupt line reports the OR of the masked status.

The pins enter asynchronously. They pass through a two-stage synchronizer and a previous-sample register before any edge is judged. Edge status bits stay set until software clears them by writing ones to a clear location. Level status bits track the pin for as long as the condition holds. A small word-addressed register bus with a write strobe and a combinational read port carries all configuration and status.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration and status word reads 0 and `irq_out` is 0. Pins that are already high when reset is released never produce edge status, even when rising-edge detection is enabled at once.
- R2: Byte offsets on `bus_addr`: 0x00 enable, 0x04 mask, 0x08 kind (1 = level, 0 = edge), 0x0C polarity, 0x10 any-edge, 0x14 clear (write only, reads 0), 0x18 raw status, 0x1C masked status. The five configuration words read back what was last written.
- R3: An enabled edge pin with polarity 0 and any-edge 0 sets its raw bit on a 0-to-1 change. The bit is set at the third rising clock edge after the pin changes, and not earlier.
- R4: An enabled edge pin with polarity 1 and any-edge 0 sets its raw bit on a 1-to-0 change. A 0-to-1 change does not set it.
- R5: An enabled edge pin with any-edge 1 sets its raw bit on both kinds of change, whatever its polarity bit holds.
- R6: An enabled level pin has its raw bit equal to (pin XOR polarity) three clock edges later. A clear write does not remove the bit while the condition holds.
- R7: Edge status is sticky. Writing a word to the clear offset zeroes exactly the edge status bits that are 1 in it. Zero bits leave status untouched. All ones clears every pin.
- R8: A pin whose enable bit is 0 never sets its raw status bit, in either edge or level mode.
- R9: Masked status equals raw status AND NOT mask. A masked pin still records raw status.
- R10: `irq_out` is the OR of the masked status bits, delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NPIN | Asynchronous pin levels |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | AW | Byte address of the word accessed |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pin change made between clock edges shows up in raw and masked status after the third rising edge. It reaches `irq_out` after the fourth. A register write or clear changes status at the edge that takes the write, and `irq_out` follows one edge later. The bench drives pins and bus on falling edges and samples on falling edges. For the edge-latency check it samples once after two edges, expecting nothing, and once after three. The interrupt line is checked one edge before and one edge after it is due. Other checks wait five cycles so that the pipeline has settled.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  output logic            irq_out
);

  localparam logic [AW-1:0] A_EN   = AW'('h00);
  localparam logic [AW-1:0] A_MASK = AW'('h04);
  localparam logic [AW-1:0] A_KIND = AW'('h08);
  localparam logic [AW-1:0] A_POL  = AW'('h0C);
  localparam logic [AW-1:0] A_ANY  = AW'('h10);
  localparam logic [AW-1:0] A_CLR  = AW'('h14);
  localparam logic [AW-1:0] A_RAW  = AW'('h18);
  localparam logic [AW-1:0] A_MSK  = AW'('h1C);

  logic [NPIN-1:0] en_r, mask_r, kind_r, pol_r, any_r;
  logic [NPIN-1:0] s1, s2, prev, raw;
  logic [2:0]      warm;
  logic            armed;
  logic [NPIN-1:0] clr_vec, rise, fall, edge_hit, lvl_hit, set_vec, raw_n, masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r   <= '0;
      mask_r <= '0;
      kind_r <= '0;
      pol_r  <= '0;
      any_r  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_EN:    en_r   <= bus_wdata;
        A_MASK:  mask_r <= bus_wdata;
        A_KIND:  kind_r <= bus_wdata;
        A_POL:   pol_r  <= bus_wdata;
        A_ANY:   any_r  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      warm <= '0;
    end else begin
      s1   <= pin_in;
      s2   <= s1;
      prev <= s2;
      warm <= {warm[1:0], 1'b1};
    end
  end

  assign armed    = warm[2];
  assign clr_vec  = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;
  assign rise     = s2 & ~prev;
  assign fall     = prev & ~s2;
  assign edge_hit = (any_r & (rise | fall)) | (~any_r & ~pol_r & rise) | (~any_r & pol_r & fall);
  assign lvl_hit  = s2 ^ pol_r;
  assign set_vec  = armed ? (en_r & ~kind_r & edge_hit) : '0;
  assign raw_n    = (kind_r & en_r & lvl_hit & {NPIN{armed}})
                  | (~kind_r & ((raw & ~clr_vec) | set_vec));
  assign masked   = raw & ~mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw     <= '0;
      irq_out <= 1'b0;
    end else begin
      raw     <= raw_n;
      irq_out <= |masked;
    end
  end

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_r;
      A_MASK:  bus_rdata = mask_r;
      A_KIND:  bus_rdata = kind_r;
      A_POL:   bus_rdata = pol_r;
      A_ANY:   bus_rdata = any_r;
      A_RAW:   bus_rdata = raw;
      A_MSK:   bus_rdata = masked;
      default: bus_rdata = '0;
    endcase
  end

  // R1
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (raw == '0));

  // R8
  disabled_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & ~$past(raw) & ~$past(en_r)) == '0));

  // R7
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(raw & ~kind_r & ~clr_vec) & ~raw) == '0));

  // R7
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw & $past(clr_vec & ~kind_r & ~set_vec)) == '0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~mask_r) == '0) |=> !irq_out);

endmodule

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  localparam int TCLK = 10;
  localparam logic [4:0] A_EN = 5'h00, A_MASK = 5'h04, A_KIND = 5'h08, A_POL = 5'h0C,
                         A_ANY = 5'h10, A_CLR = 5'h14, A_RAW = 5'h18, A_MSK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = 32'hFFFF_0000;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  gpio_irq_detect #(.NPIN(32), .AW(5)) i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  always #(TCLK/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic cfg_zero();
    wr(A_EN, 0); wr(A_MASK, 0); wr(A_KIND, 0); wr(A_POL, 0); wr(A_ANY, 0);
    wr(A_CLR, 32'hFFFF_FFFF);
    tick(2);
  endtask

  task automatic t_reset();
    tick(3);
    rst_n = 1'b1;
    rd_chk("R1 enable", A_EN, 0);
    rd_chk("R1 mask", A_MASK, 0);
    rd_chk("R1 raw", A_RAW, 0);
    check("R1 irq", {31'b0, irq_out}, 0);
    wr(A_EN, 32'hFFFF_FFFF);
    tick(6);
    rd_chk("R1 no false edge", A_RAW, 0);
    check("R1 irq quiet", {31'b0, irq_out}, 0);
    wr(A_EN, 0);
  endtask

  task automatic t_regmap();
    wr(A_EN, 32'h0000_1234); wr(A_MASK, 32'hA5A5_0000); wr(A_KIND, 32'h0F00_0000);
    wr(A_POL, 32'h00F0_0000); wr(A_ANY, 32'h0000_00C0);
    rd_chk("R2 enable", A_EN, 32'h0000_1234);
    rd_chk("R2 mask", A_MASK, 32'hA5A5_0000);
    rd_chk("R2 kind", A_KIND, 32'h0F00_0000);
    rd_chk("R2 polarity", A_POL, 32'h00F0_0000);
    rd_chk("R2 any-edge", A_ANY, 32'h0000_00C0);
    rd_chk("R2 clear reads 0", A_CLR, 0);
    cfg_zero();
  endtask

  task automatic t_rise();
    wr(A_EN, 32'h1);
    pins[0] = 1'b1;
    tick(2);
    rd_chk("R3 not before third edge", A_RAW, 0);
    tick(1);
    rd_chk("R3 rising sets", A_RAW, 32'h1);
    rd_chk("R9 masked follows", A_MSK, 32'h1);
    check("R10 irq one cycle later", {31'b0, irq_out}, 0);
    tick(1);
    check("R10 irq asserted", {31'b0, irq_out}, 1);
    pins[0] = 1'b0;
    tick(5);
    rd_chk("R7 edge sticky", A_RAW, 32'h1);
    wr(A_CLR, 32'h1);
    rd_chk("R7 cleared", A_RAW, 0);
    tick(1);
    check("R10 irq drops", {31'b0, irq_out}, 0);
    cfg_zero();
  endtask

  task automatic t_fall();
    wr(A_POL, 32'h2); wr(A_EN, 32'h2);
    pins[1] = 1'b1;
    tick(5);
    rd_chk("R4 rising ignored", A_RAW, 0);
    pins[1] = 1'b0;
    tick(5);
    rd_chk("R4 falling sets", A_RAW, 32'h2);
    cfg_zero();
  endtask

  task automatic t_both();
    wr(A_ANY, 32'h4); wr(A_POL, 32'h4); wr(A_EN, 32'h4);
    pins[2] = 1'b1;
    tick(5);
    rd_chk("R5 rise with polarity 1", A_RAW, 32'h4);
    wr(A_CLR, 32'h4);
    tick(2);
    rd_chk("R5 quiet after clear", A_RAW, 0);
    pins[2] = 1'b0;
    tick(5);
    rd_chk("R5 fall sets", A_RAW, 32'h4);
    cfg_zero();
  endtask

  task automatic t_level();
    wr(A_KIND, 32'h8); wr(A_EN, 32'h8);
    pins[3] = 1'b1;
    tick(5);
    rd_chk("R6 high level", A_RAW, 32'h8);
    check("R10 irq level", {31'b0, irq_out}, 1);
    wr(A_CLR, 32'h8);
    rd_chk("R6 clear no effect while held", A_RAW, 32'h8);
    pins[3] = 1'b0;
    tick(3);
    rd_chk("R6 follows low", A_RAW, 0);
    tick(1);
    check("R10 irq released", {31'b0, irq_out}, 0);
    wr(A_POL, 32'h8);
    tick(3);
    rd_chk("R6 low level", A_RAW, 32'h8);
    pins[3] = 1'b1;
    tick(5);
    rd_chk("R6 low level released", A_RAW, 0);
    pins[3] = 1'b0;
    cfg_zero();
  endtask

  task automatic t_enable();
    pins[4] = 1'b1;
    tick(5);
    pins[4] = 1'b0;
    tick(5);
    rd_chk("R8 disabled edge", A_RAW, 0);
    wr(A_KIND, 32'h10);
    pins[4] = 1'b1;
    tick(5);
    rd_chk("R8 disabled level", A_RAW, 0);
    wr(A_EN, 32'h10);
    tick(2);
    rd_chk("R8 enabled level sets", A_RAW, 32'h10);
    pins[4] = 1'b0;
    cfg_zero();
  endtask

  task automatic t_mask();
    wr(A_MASK, 32'h20); wr(A_EN, 32'h20);
    pins[5] = 1'b1;
    tick(6);
    rd_chk("R9 raw recorded", A_RAW, 32'h20);
    rd_chk("R9 masked hidden", A_MSK, 0);
    check("R9 irq blocked", {31'b0, irq_out}, 0);
    wr(A_MASK, 0);
    rd_chk("R9 unmasked", A_MSK, 32'h20);
    tick(1);
    check("R10 irq after unmask", {31'b0, irq_out}, 1);
    pins[5] = 1'b0;
    cfg_zero();
  endtask

  task automatic t_clear();
    wr(A_EN, 32'h1C0);
    pins[8:6] = 3'b111;
    tick(5);
    rd_chk("R7 three set", A_RAW, 32'h1C0);
    wr(A_CLR, 32'h40);
    rd_chk("R7 one cleared", A_RAW, 32'h180);
    wr(A_CLR, 0);
    rd_chk("R7 zero write", A_RAW, 32'h180);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd_chk("R7 all ones", A_RAW, 0);
    pins[8:6] = 3'b000;
    cfg_zero();
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_enable();
    t_mask();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule